// File: doc/BRIEF.md
# Flash Erase Block Select Registers

This block holds the choice of which single flash block may be erased. Two byte-wide registers sit on a simple byte bus. The low register covers blocks 0 to 7. The high register covers blocks 8 upward, and the number of blocks it holds is set by a parameter. The erase sequencer outside this block reads a combined enable vector. At most one bit of that vector is ever high. Every block whose bit is low is protected from erase.

The registers guard themselves in two ways. First, a write that would leave two or more blocks selected across the pair clears both registers. Second, either standby mode clears both registers, and so does any state of the write-enable pin and the software write-enable bit that does not allow programming. When the on-chip flash is switched off, reads return zero and writes do nothing.

Top module: `flash_erase_select`

## Requirements
- R1: With `reg_sel`=0 the bus addresses the low register, whose bit i drives `erase_en[i]` for i in 0..7. With `reg_sel`=1 it addresses the high register, whose bit i drives `erase_en[8+i]`.
- R2: While `rst_n` is low, both registers and `erase_en` are zero. Reset is asynchronous.
- R3: If any of `hw_standby`=1, `sw_standby`=1, `wen_pin`=0 or `sw_wen`=0 holds at a rising clock edge, both registers are zero after that edge. This takes priority over a write in the same cycle.
- R4: A write (`wr_en`=1 at a rising edge, flash on, no clear condition) that leaves at most one bit set across both registers stores the written byte. The byte can be read back on `rd_data`.
- R5: A write whose result has two or more bits set across both registers clears both registers. `erase_en` is always zero or one-hot.
- R6: High-register bits at `HI_BLOCKS` and above always read 0. Write data in those bits is discarded before the one-hot check, so it cannot trigger a clear.
- R7: While `flash_on`=0, `rd_data` is 0x00 for either register.
- R8: While `flash_on`=0, writes leave both registers unchanged.
- R9: Writing 0x00 to the register that holds the selected bit removes the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby active |
| sw_standby | input | 1 | Software standby active |
| wen_pin | input | 1 | Flash write-enable pin level |
| sw_wen | input | 1 | Software write-enable bit |
| flash_on | input | 1 | On-chip flash enabled |
| reg_sel | input | 1 | 0 = low register, 1 = high register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| erase_en | output | 8+HI_BLOCKS | Per-block erase enable |

## Verification
The assertions assume that the status inputs change only away from the clock edge. They also assume that `HI_BLOCKS` is 2, 4 or 6, so the reserved-bit check always has at least two bits to look at. The bench drives every input on the falling edge and keeps the default of six high blocks. It holds the protection inputs in their permissive state during table writes and moves them only in the directed tests.

// File: rtl/flash_erase_select.sv
module flash_erase_select #(
  parameter int HI_BLOCKS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hw_standby,
  input  logic                   sw_standby,
  input  logic                   wen_pin,
  input  logic                   sw_wen,
  input  logic                   flash_on,
  input  logic                   reg_sel,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  output logic [8+HI_BLOCKS-1:0] erase_en
);
  localparam int NBLK = 8 + HI_BLOCKS;

  logic [7:0]           lo_q;
  logic [HI_BLOCKS-1:0] hi_q;
  logic [NBLK-1:0]      next_sel;
  logic                 force_clr;
  logic                 do_wr;

  assign force_clr = hw_standby | sw_standby | ~wen_pin | ~sw_wen;
  assign do_wr     = wr_en & flash_on;
  assign next_sel  = reg_sel ? {wr_data[HI_BLOCKS-1:0], lo_q} : {hi_q, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (force_clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (do_wr) begin
      if ($countones(next_sel) > 1) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        lo_q <= next_sel[7:0];
        hi_q <= next_sel[NBLK-1:8];
      end
    end
  end

  assign rd_data  = !flash_on ? 8'h00 :
                    reg_sel   ? {{(8-HI_BLOCKS){1'b0}}, hi_q} : lo_q;
  assign erase_en = {hi_q, lo_q};
endmodule

// File: rtl/flash_erase_select_chk.sv
module flash_erase_select_chk #(
  parameter int HI_BLOCKS = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hw_standby,
  input logic                   sw_standby,
  input logic                   wen_pin,
  input logic                   sw_wen,
  input logic                   flash_on,
  input logic                   reg_sel,
  input logic [7:0]             rd_data,
  input logic [8+HI_BLOCKS-1:0] erase_en
);
  logic protect;
  assign protect = hw_standby | sw_standby | ~wen_pin | ~sw_wen;

  a_r2_reset_zero: assert property (@(posedge clk) !rst_n |-> erase_en == '0);

  a_r3_forced_clear: assert property (@(posedge clk) disable iff (!rst_n)
    protect |=> erase_en == '0);

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_en));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (rd_data >> HI_BLOCKS) == 8'h00);

  a_r7_read_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_on |-> rd_data == 8'h00);

  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && !protect) |=> $stable(erase_en));
endmodule

bind flash_erase_select flash_erase_select_chk #(.HI_BLOCKS(HI_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
  .wen_pin(wen_pin), .sw_wen(sw_wen), .flash_on(flash_on), .reg_sel(reg_sel),
  .rd_data(rd_data), .erase_en(erase_en)
);

// File: tb/flash_erase_select_bench.sv
module flash_erase_select_bench;
  localparam int HI = 6;
  localparam int NV = 12;

  logic clk = 0, rst_n = 0;
  logic hw_standby = 0, sw_standby = 0, wen_pin = 1, sw_wen = 1, flash_on = 1;
  logic reg_sel = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [8+HI-1:0] erase_en;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_erase_select #(.HI_BLOCKS(HI)) u_flash_erase_select (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .wen_pin(wen_pin), .sw_wen(sw_wen), .flash_on(flash_on), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .erase_en(erase_en)
  );

  // {sel, data, expected low, expected high}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h01, 8'h00},  // R4, R1
    {1'b1, 8'h04, 8'h00, 8'h00},  // R5 across registers
    {1'b1, 8'h04, 8'h00, 8'h04},  // R4, R1
    {1'b0, 8'h80, 8'h00, 8'h00},  // R5
    {1'b0, 8'h80, 8'h80, 8'h00},  // R4
    {1'b0, 8'h00, 8'h00, 8'h00},  // R9
    {1'b1, 8'hC0, 8'h00, 8'h00},  // R6
    {1'b1, 8'hE0, 8'h00, 8'h20},  // R6 masked before check
    {1'b1, 8'h03, 8'h00, 8'h00},  // R5 within one register
    {1'b0, 8'h10, 8'h10, 8'h00},  // R4
    {1'b0, 8'h11, 8'h00, 8'h00},  // R5
    {1'b1, 8'h20, 8'h00, 8'h20}   // R4
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic expect_regs(string req, logic [7:0] lo, logic [7:0] hi);
    reg_sel = 0; #1;
    check(req, rd_data, lo);
    reg_sel = 1; #1;
    check(req, rd_data, hi);
    check(req, erase_en, {hi[HI-1:0], lo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2;
    expect_regs("R2 reset", 8'h00, 8'h00);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][24], VEC[i][23:16]);
      expect_regs($sformatf("R4/R5 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
    end

    wr(1, 8'h20);
    @(negedge clk); hw_standby = 1; @(negedge clk); hw_standby = 0;
    expect_regs("R3 hw_standby", 8'h00, 8'h00);
    wr(0, 8'h02);
    @(negedge clk); sw_standby = 1; @(negedge clk); sw_standby = 0;
    expect_regs("R3 sw_standby", 8'h00, 8'h00);
    wr(0, 8'h02);
    @(negedge clk); wen_pin = 0; @(negedge clk); wen_pin = 1;
    expect_regs("R3 pin low", 8'h00, 8'h00);
    wr(1, 8'h01);
    @(negedge clk); sw_wen = 0; @(negedge clk); sw_wen = 1;
    expect_regs("R3 sw_wen clear", 8'h00, 8'h00);
    @(negedge clk); hw_standby = 1; reg_sel = 0; wr_data = 8'h08; wr_en = 1;
    @(negedge clk); hw_standby = 0; wr_en = 0;
    expect_regs("R3 priority over write", 8'h00, 8'h00);

    wr(0, 8'h02);
    @(negedge clk); flash_on = 0;
    reg_sel = 0; #1; check("R7 read low off", rd_data, 8'h00);
    reg_sel = 1; #1; check("R7 read high off", rd_data, 8'h00);
    wr(0, 8'h08);
    wr(1, 8'h01);
    check("R8 erase_en unchanged", erase_en, 14'h0002);
    @(negedge clk); flash_on = 1;
    expect_regs("R8 write ignored", 8'h02, 8'h00);

    wr(1, 8'h02);
    expect_regs("R5 cross clear", 8'h00, 8'h00);
    wr(1, 8'h02);
    @(negedge clk); rst_n = 0; #1;
    expect_regs("R2 async reset", 8'h00, 8'h00);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule